// File: doc/BRIEF.md
# SPI Flash Bring-Up Sequencer

This block is a host-side SPI master that prepares a serial data flash for use after power-up. A pulse on `start` runs a fixed script. The sequencer first reads the identification bytes and checks the manufacturer code. It then reads the status register until the device reports ready. If the status shows that the binary (power-of-two) page size is not yet set, the sequencer sends the four-byte one-time configuration command and polls status again. After that it either reports success or gives up after a bounded number of attempts. When the configuration was written during this run, the sequencer also flags that the device must be power cycled before the new page size takes effect. The system performs that power cycle; this block does not.

The serial clock is the system clock divided down. SCK idles low (SPI mode 0), and every command sits in its own chip-select frame. A minimum chip-select-high time separates one frame from the next. The script has no path that can emit either of the chip-erase opcode groups.

The states are named as follows:

- `ST_IDLE`: waiting for `start`.
- `ST_GAP`: chip select high for the guard time, then move to the stored next state.
- `ST_ID_OP`: send the identification opcode.
- `ST_ID_DATA`: clock in the manufacturer byte.
- `ST_STAT_OP`: send the status opcode.
- `ST_STAT_DATA`: clock in the status byte.
- `ST_CFG`: send the four configuration bytes.
- `ST_DONE`: success.
- `ST_ERROR`: failure.

The transitions are:

- From `ST_IDLE`, `ST_DONE` or `ST_ERROR`, `start` leads to `ST_GAP`, targeting `ST_ID_OP`.
- `ST_GAP` moves to its target once the guard time has elapsed.
- `ST_ID_OP` moves to `ST_ID_DATA` when the byte ends.
- `ST_ID_DATA` moves to `ST_GAP` (targeting `ST_STAT_OP`) when the byte matches, and to `ST_ERROR` when it does not.
- `ST_STAT_OP` moves to `ST_STAT_DATA` when the byte ends.
- `ST_STAT_DATA` moves to one of four states:
  - to `ST_GAP` (targeting `ST_STAT_OP`) when the device is busy and polls remain;
  - to `ST_ERROR` when the poll limit is reached or the configuration attempts are used up;
  - to `ST_DONE` when the device is ready with the page bit set;
  - to `ST_GAP` (targeting `ST_CFG`) when the device is ready with the page bit clear and attempts remain.
- `ST_CFG` moves to `ST_GAP` (targeting `ST_STAT_OP`) after its fourth byte.

Top module: `flash_bringup_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `done`, `error` and `needs_power_cycle` are all 0.
- R2: `spi_sck` is 0 whenever `spi_cs_n` is 1. Each high and each low half of SCK lasts CLK_DIV system clocks. Bytes go out MSB first on `spi_mosi`, which changes only while SCK is low. Returned bits are captured MSB first at SCK rising edges.
- R3: The first frame after `start` carries opcode 9Fh followed by one read byte. If that byte differs from MFR_ID (default 1Fh), `error` rises and no further frame is sent.
- R4: Status is read with a two-byte frame whose opcode is D7h. Bit 7 = 1 means ready. A busy read is followed by another status frame. POLL_LIMIT consecutive busy reads end the run in `error`.
- R5: If the first ready status has bit 0 = 1, `done` rises with `needs_power_cycle` = 0 and no configuration frame is sent.
- R6: If a ready status has bit 0 = 0, one frame carrying exactly 3Dh, 2Ah, 80h, A6h is sent, and status polling then resumes.
- R7: When a run ends with success after at least one configuration frame, `needs_power_cycle` is 1 together with `done`.
- R8: At most CFG_RETRIES configuration frames are sent per run. A ready status with bit 0 = 0 after the last of them ends the run in `error`.
- R9: Between any two frames, `spi_cs_n` stays high for at least CS_GAP system clocks.
- R10: No frame ever starts with C7h or 94h.
- R11: `start` has no effect while a run is in progress. A `start` after success or failure begins a new run and clears `done`, `error` and `needs_power_cycle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a bring-up run |
| done | output | 1 | Run finished successfully (level, held until next run) |
| error | output | 1 | Run finished with a fault (level, held until next run) |
| needs_power_cycle | output | 1 | Configuration was written this run; power cycle required |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that `spi_miso` changes only between SCK falling and rising edges, that the device answers each status frame with a full byte, and that `start` is a one-cycle pulse that is synchronous to `clk`. The bench flash model updates its output only on observed SCK falls and keeps its status in step with whole frames. The bench drives `start` away from the clock edge for exactly one cycle. It also issues a second pulse in mid-run to show that the pulse is ignored.

// File: rtl/flash_bringup_pkg.sv
package flash_bringup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_ID_OP,
        ST_ID_DATA,
        ST_STAT_OP,
        ST_STAT_DATA,
        ST_CFG,
        ST_DONE,
        ST_ERROR
    } seq_state_t;

    localparam logic [7:0] OP_READ_ID = 8'h9F;
    localparam logic [7:0] OP_STATUS  = 8'hD7;
    localparam logic [7:0] OP_DUMMY   = 8'h00;

    // opcodes that must never open a frame
    localparam logic [7:0] OP_BANNED_A = 8'hC7;
    localparam logic [7:0] OP_BANNED_B = 8'h94;

    localparam int STAT_READY_BIT = 7;
    localparam int STAT_PAGE_BIT  = 0;

    function automatic logic [7:0] cfg_byte(input logic [1:0] idx);
        logic [7:0] b;
        case (idx)
            2'd0:    b = 8'h3D;
            2'd1:    b = 8'h2A;
            2'd2:    b = 8'h80;
            default: b = 8'hA6;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);

    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

    phase_t        phase;
    logic [DW-1:0] div_cnt;
    logic [2:0]    bits_left;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;
    logic          half_end;

    assign half_end = (div_cnt == DW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            div_cnt   <= '0;
            bits_left <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sck       <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        tx_sh     <= tx_byte;
                        bits_left <= 3'd7;
                        div_cnt   <= '0;
                        phase     <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (half_end) begin
                        div_cnt <= '0;
                        sck     <= 1'b1;
                        rx_sh   <= {rx_sh[6:0], miso};
                        phase   <= PH_HIGH;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (half_end) begin
                        div_cnt <= '0;
                        sck     <= 1'b0;
                        if (bits_left == 3'd0) begin
                            phase     <= PH_IDLE;
                            byte_done <= 1'b1;
                        end else begin
                            bits_left <= bits_left - 1'b1;
                            tx_sh     <= {tx_sh[6:0], 1'b0};
                            phase     <= PH_LOW;
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign mosi    = tx_sh[7];
    assign rx_byte = rx_sh;

    // R2: data toward the flash holds still while the clock is high
    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));

endmodule

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
    parameter int GAP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic met
);

    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!met) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign met = run && (cnt == CW'(GAP_CYCLES - 1));

endmodule

// File: rtl/flash_bringup_seq.sv
module flash_bringup_seq
    import flash_bringup_pkg::*;
#(
    parameter int         CLK_DIV     = 2,
    parameter int         CS_GAP      = 4,
    parameter int         POLL_LIMIT  = 100000,
    parameter int         CFG_RETRIES = 2,
    parameter logic [7:0] MFR_ID      = 8'h1F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic error,
    output logic needs_power_cycle,
    output logic spi_cs_n,
    output logic spi_sck,
    output logic spi_mosi,
    input  logic spi_miso
);

    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int TW = $clog2(CFG_RETRIES + 1);
    localparam int HW = $clog2(CS_GAP + 2);

    seq_state_t    state;
    seq_state_t    gap_next;
    logic          launched;
    logic [1:0]    byte_idx;
    logic [PW-1:0] poll_cnt;
    logic [TW-1:0] cfg_tries;
    logic          cfg_issued;

    logic          eng_go;
    logic [7:0]    eng_tx;
    logic          eng_done;
    logic [7:0]    eng_rx;
    logic          gap_met;
    logic          in_frame;
    logic          frame_first;

    spi_byte_engine #(.HALF_DIV(CLK_DIV)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (eng_go),
        .tx_byte   (eng_tx),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .byte_done (eng_done),
        .rx_byte   (eng_rx)
    );

    cs_gap_timer #(.GAP_CYCLES(CS_GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_GAP),
        .met   (gap_met)
    );

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            gap_next   <= ST_ID_OP;
            launched   <= 1'b0;
            byte_idx   <= '0;
            poll_cnt   <= '0;
            cfg_tries  <= '0;
            cfg_issued <= 1'b0;
        end else begin
            if (eng_go) launched <= 1'b1;
            unique case (state)
                ST_IDLE, ST_DONE, ST_ERROR: begin
                    if (start) begin
                        poll_cnt   <= '0;
                        cfg_tries  <= '0;
                        cfg_issued <= 1'b0;
                        gap_next   <= ST_ID_OP;
                        state      <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_met) begin
                        state    <= gap_next;
                        launched <= 1'b0;
                        byte_idx <= '0;
                    end
                end
                ST_ID_OP: begin
                    if (eng_done) begin
                        state    <= ST_ID_DATA;
                        launched <= 1'b0;
                    end
                end
                ST_ID_DATA: begin
                    if (eng_done) begin
                        if (eng_rx == MFR_ID) begin
                            gap_next <= ST_STAT_OP;
                            state    <= ST_GAP;
                        end else begin
                            state <= ST_ERROR;
                        end
                    end
                end
                ST_STAT_OP: begin
                    if (eng_done) begin
                        state    <= ST_STAT_DATA;
                        launched <= 1'b0;
                    end
                end
                ST_STAT_DATA: begin
                    if (eng_done) begin
                        if (!eng_rx[STAT_READY_BIT]) begin
                            if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                                state <= ST_ERROR;
                            end else begin
                                poll_cnt <= poll_cnt + 1'b1;
                                gap_next <= ST_STAT_OP;
                                state    <= ST_GAP;
                            end
                        end else begin
                            poll_cnt <= '0;
                            if (eng_rx[STAT_PAGE_BIT]) begin
                                state <= ST_DONE;
                            end else if (cfg_tries == TW'(CFG_RETRIES)) begin
                                state <= ST_ERROR;
                            end else begin
                                cfg_tries  <= cfg_tries + 1'b1;
                                cfg_issued <= 1'b1;
                                gap_next   <= ST_CFG;
                                state      <= ST_GAP;
                            end
                        end
                    end
                end
                ST_CFG: begin
                    if (eng_done) begin
                        if (byte_idx == 2'd3) begin
                            gap_next <= ST_STAT_OP;
                            state    <= ST_GAP;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            launched <= 1'b0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        in_frame    = 1'b0;
        frame_first = 1'b0;
        eng_tx      = OP_DUMMY;
        unique case (state)
            ST_ID_OP: begin
                in_frame    = 1'b1;
                frame_first = 1'b1;
                eng_tx      = OP_READ_ID;
            end
            ST_STAT_OP: begin
                in_frame    = 1'b1;
                frame_first = 1'b1;
                eng_tx      = OP_STATUS;
            end
            ST_ID_DATA, ST_STAT_DATA: begin
                in_frame = 1'b1;
            end
            ST_CFG: begin
                in_frame    = 1'b1;
                frame_first = (byte_idx == 2'd0);
                eng_tx      = cfg_byte(byte_idx);
            end
            default: begin
                in_frame = 1'b0;
            end
        endcase
        eng_go            = in_frame && !launched;
        spi_cs_n          = !in_frame;
        done              = (state == ST_DONE);
        error             = (state == ST_ERROR);
        needs_power_cycle = (state == ST_DONE) && cfg_issued;
    end

    // checker-side count of chip-select-high cycles
    logic [HW-1:0] chk_hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_hi_cnt <= '0;
        end else if (!spi_cs_n) begin
            chk_hi_cnt <= '0;
        end else if (chk_hi_cnt != HW'(CS_GAP)) begin
            chk_hi_cnt <= chk_hi_cnt + 1'b1;
        end
    end

    // R2: serial clock rests low outside a frame
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R9: guard time before every new frame
    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (chk_hi_cnt >= HW'(CS_GAP)));

    // R10: a frame never opens with an erase-all opcode
    p_no_erase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_go && frame_first) |-> (eng_tx != OP_BANNED_A && eng_tx != OP_BANNED_B));

    // R8: configuration attempts stay within the limit
    p_cfg_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CFG) |-> (cfg_tries <= TW'(CFG_RETRIES)));

    // R11: a run in progress does not restart on start
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_STAT_DATA && !eng_done) |=> (state == ST_STAT_DATA));

endmodule

// File: tb/flash_bringup_seq_tb.sv
`timescale 1ns/1ps
module flash_bringup_seq_tb;

    localparam int CLK_DIV     = 2;
    localparam int CS_GAP      = 4;
    localparam int POLL_LIMIT  = 8;
    localparam int CFG_RETRIES = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, error, needs_power_cycle;
    logic spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    always #4 clk = ~clk;

    flash_bringup_seq #(
        .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT),
        .CFG_RETRIES(CFG_RETRIES), .MFR_ID(8'h1F)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
        .needs_power_cycle(needs_power_cycle), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // model settings, written only by tasks
    int         gen = 0;
    logic [7:0] id_val = 8'h1F;
    int         init_busy = 0;
    int         fix_after = 0;
    int         busy_after_cfg = 0;

    // model state, written only by the model block
    int         last_gen = 0;
    int         frames = 0;
    int         cfg_cnt = 0;
    int         busy_rem = 0;
    bit         cfg_frame_ok = 1;
    logic [7:0] ops [0:31];
    logic [7:0] fb [0:7];
    logic [7:0] shreg = 8'h00;
    int         bits = 0;
    int         nbytes = 0;
    int         hi_run = 100;
    int         sck_run = 0;
    int         gap_viol = 0;
    int         erase_viol = 0;
    int         idle_viol = 0;
    int         clk_viol = 0;
    logic       prev_cs = 1'b1;
    logic       prev_sck = 1'b0;

    function automatic logic [7:0] resp_byte(input int idx);
        logic [7:0] r;
        r = 8'h00;
        if (fb[0] == 8'h9F) begin
            case (idx)
                1: r = id_val;
                2: r = 8'h27;
                3: r = 8'h01;
                default: r = 8'h00;
            endcase
        end else if (fb[0] == 8'hD7) begin
            r = {(busy_rem == 0), 6'b0, (cfg_cnt >= fix_after)};
        end
        return r;
    endfunction

    always @(negedge clk) begin
        logic [7:0] rb;
        if (gen != last_gen) begin
            last_gen     = gen;
            frames       = 0;
            cfg_cnt      = 0;
            busy_rem     = init_busy;
            cfg_frame_ok = 1;
        end
        if (spi_cs_n && spi_sck) idle_viol++;
        if (prev_cs && !spi_cs_n) begin
            bits   = 0;
            nbytes = 0;
            for (int k = 0; k < 8; k++) fb[k] = 8'h00;
            if (hi_run < CS_GAP) gap_viol++;
        end
        if (spi_cs_n) hi_run++; else hi_run = 0;
        if (spi_sck) sck_run++;
        if (prev_sck && !spi_sck) begin
            if (sck_run != CLK_DIV) clk_viol++;
            sck_run = 0;
        end
        if (!spi_cs_n && !prev_sck && spi_sck) begin
            shreg = {shreg[6:0], spi_mosi};
            bits++;
            if (bits == 8) begin
                bits = 0;
                if (nbytes < 8) fb[nbytes] = shreg;
                nbytes++;
            end
        end
        if (!spi_cs_n && prev_sck && !spi_sck && nbytes >= 1) begin
            rb = resp_byte(nbytes);
            spi_miso = rb[7 - bits];
        end
        if (!prev_cs && spi_cs_n) begin
            if (frames < 32) ops[frames] = fb[0];
            frames++;
            if (fb[0] == 8'hC7 || fb[0] == 8'h94) erase_viol++;
            if (fb[0] == 8'h3D) begin
                if (!(nbytes == 4 && fb[1] == 8'h2A && fb[2] == 8'h80 && fb[3] == 8'hA6))
                    cfg_frame_ok = 0;
                cfg_cnt++;
                busy_rem = busy_after_cfg;
            end else if (fb[0] == 8'hD7 && busy_rem > 0) begin
                busy_rem--;
            end
        end
        prev_cs  = spi_cs_n;
        prev_sck = spi_sck;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (done || error) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic new_case(input logic [7:0] id, input int busy0, input int fix, input int busy_cfg);
        id_val         = id;
        init_busy      = busy0;
        fix_after      = fix;
        busy_after_cfg = busy_cfg;
        gen++;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(spi_cs_n === 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
        chk(spi_sck === 1'b0, "R1 sck", int'(spi_sck), 0);
        chk({done, error, needs_power_cycle} === 3'b000, "R1 flags",
            int'({done, error, needs_power_cycle}), 0);
    endtask

    task automatic t_binary(input string tag);
        new_case(8'h1F, 0, 0, 0);
        pulse_start();
        wait_end();
        chk(done === 1'b1 && error === 1'b0, {tag, " R5 done"}, int'({done, error}), 2);
        chk(needs_power_cycle === 1'b0, {tag, " R5 npc"}, int'(needs_power_cycle), 0);
        chk(cfg_cnt == 0, {tag, " R5 no cfg"}, cfg_cnt, 0);
        chk(frames == 2, {tag, " R4 frames"}, frames, 2);
        chk(ops[0] == 8'h9F, {tag, " R3 id op"}, int'(ops[0]), 'h9F);
        chk(ops[1] == 8'hD7, {tag, " R4 stat op"}, int'(ops[1]), 'hD7);
    endtask

    task automatic t_config();
        new_case(8'h1F, 2, 1, 3);
        pulse_start();
        repeat (150) @(negedge clk);
        pulse_start();
        wait_end();
        chk(done === 1'b1 && error === 1'b0, "R7 done", int'({done, error}), 2);
        chk(needs_power_cycle === 1'b1, "R7 npc", int'(needs_power_cycle), 1);
        chk(cfg_cnt == 1, "R6 cfg count", cfg_cnt, 1);
        chk(cfg_frame_ok, "R6 cfg bytes", int'(cfg_frame_ok), 1);
        chk(ops[4] == 8'h3D, "R6 cfg position", int'(ops[4]), 'h3D);
        chk(frames == 9, "R11 R4 frames", frames, 9);
    endtask

    task automatic t_bad_id();
        new_case(8'h1E, 0, 0, 0);
        pulse_start();
        wait_end();
        chk(error === 1'b1 && done === 1'b0, "R3 error", int'({done, error}), 1);
        chk(frames == 1, "R3 frames", frames, 1);
    endtask

    task automatic t_timeout();
        new_case(8'h1F, 100, 0, 0);
        pulse_start();
        wait_end();
        chk(error === 1'b1, "R4 timeout error", int'(error), 1);
        chk(frames == 1 + POLL_LIMIT, "R4 poll count", frames, 1 + POLL_LIMIT);
    endtask

    task automatic t_retry();
        new_case(8'h1F, 0, 99, 1);
        pulse_start();
        wait_end();
        chk(error === 1'b1 && done === 1'b0, "R8 error", int'({done, error}), 1);
        chk(cfg_cnt == CFG_RETRIES, "R8 attempts", cfg_cnt, CFG_RETRIES);
        chk(frames == 8, "R8 frames", frames, 8);
    endtask

    task automatic t_monitors();
        chk(idle_viol == 0, "R2 sck idle", idle_viol, 0);
        chk(clk_viol == 0, "R2 half period", clk_viol, 0);
        chk(gap_viol == 0, "R9 cs gap", gap_viol, 0);
        chk(erase_viol == 0, "R10 erase opcode", erase_viol, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_binary("first");
        t_config();
        t_binary("R11 npc cleared");
        t_bad_id();
        t_timeout();
        t_retry();
        t_binary("R11 after error");
        t_monitors();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule